// File: doc/BRIEF.md
# Serial Flash Controller Bus-Side FIFO and Status

This block is the register-facing half of a serial flash controller. A byte-wide data register is backed by a FIFO. In read direction the serial sequencer fills the FIFO and software drains it through the data register. In write direction software fills the FIFO and the sequencer drains it.

The block keeps three kinds of state:
- a threshold flag whose meaning follows the transfer direction;
- sticky completion and error flags, cleared by a write of one to a separate clear register;
- an abort request that the hardware retires by itself.

An interrupt line is raised by any flag whose enable bit is set.

Software typically polls the threshold flag and moves one byte per poll, then waits for the completion flag. Abort is used to cut a transfer short: it empties the FIFO and holds the sequencer in its abort state until the sequencer reports that it is idle.

Top module: `flashfifoStatus`

## Requirements
- R1: After reset, the control register (address 0) reads 0, the status register (address 1) reads 0 when `seqActive` is low, and `irq` is low.
- R2: In read direction (`seqReadDir`=1) with the controller enabled (control bit 0), bytes accepted from the sequencer are returned by reads of the data register (address 3, bits 7:0) in arrival order. Status bits 13:8 give the current fill level.
- R3: In write direction (`seqReadDir`=0), bytes written to the data register appear on `seqOutData` in write order, while `seqOutValid` is high.
- R4: Status bit 2 is the threshold flag. It is set in read direction when level > threshold (control bits 12:8). It is set in write direction when (depth − level) > threshold.
- R5: Status bit 1 (done) is set by a `seqDone` pulse, and status bit 0 (error) is set by a `seqError` pulse. Each stays set until a write to the clear register (address 2) has a one in the matching bit. A set in the same cycle as a clear wins.
- R6: `irq` is high when any flag is set and its enable bit is set. The enables are control bit 16 for error, bit 17 for done and bit 18 for threshold.
- R7: Writing control bit 1 (abort) sets it. While it is set, the FIFO is emptied and `seqAbort` is high. The bit clears one cycle after `seqActive` is low. Abort never sets the error flag.
- R8: With control bit 0 clear, `seqInReady` and `seqOutValid` stay low and the FIFO is held empty. Writing zero to the control register therefore disables and empties it.
- R9: A data-register read with the FIFO empty returns 0 and leaves the level unchanged. A data-register write with the FIFO full is dropped.
- R10: Status bit 5 (busy) is high when `seqActive` is high or the FIFO is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (pops the data register) |
| regAddr | input | 2 | Register select: 0 control, 1 status, 2 clear, 3 data |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational on regAddr |
| seqReadDir | input | 1 | 1 = flash-to-bus transfer, 0 = bus-to-flash |
| seqActive | input | 1 | Sequencer is running a transaction |
| seqInValid | input | 1 | Sequencer offers a received byte |
| seqInData | input | 8 | Received byte |
| seqInReady | output | 1 | FIFO accepts the received byte |
| seqOutValid | output | 1 | FIFO offers a byte to transmit |
| seqOutData | output | 8 | Byte to transmit |
| seqOutReady | input | 1 | Sequencer takes the offered byte |
| seqDone | input | 1 | Transfer-complete pulse |
| seqError | input | 1 | Transfer-error pulse |
| seqAbort | output | 1 | Abort request to the sequencer |
| irq | output | 1 | Interrupt output |

## Verification
The hardest situation to reach is an abort that is still pending: the abort bit must be observed set with the FIFO already flushed while the sequencer still claims to be active. A bench that keeps `seqActive` low would see the bit clear almost at once. The stimulus first fills the FIFO in write direction, then raises `seqActive` before the abort write. It holds `seqActive` high for several cycles, sampling control and status, and only then drops it to watch the bit retire.

The full-FIFO write drop and the same-cycle set-versus-clear race are reached the same way: the bench drives the exact cycle through the register port rather than waiting for them to happen.

// File: rtl/flashfifo_pkg.sv
package flashfifo_pkg;
  localparam int RegW = 32;
  localparam logic [1:0] AddrCtrl  = 2'd0;
  localparam logic [1:0] AddrStat  = 2'd1;
  localparam logic [1:0] AddrClear = 2'd2;
  localparam logic [1:0] AddrData  = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pushFromBus;
    logic pop;
    logic flush;
  } fifoStrobes_t;
endpackage

// File: rtl/flashfifoDatapath.sv
module flashfifoDatapath
  import flashfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DATAW = 8,
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVLW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobes_t     strb,
  input  logic [DATAW-1:0] busData,
  input  logic [DATAW-1:0] seqData,
  output logic [DATAW-1:0] headData,
  output logic [LVLW-1:0]  level,
  output logic             full,
  output logic             empty
);
  logic [PTRW-1:0]  wrPtr, rdPtr;
  logic [DATAW-1:0] store [DEPTH];
  logic [DATAW-1:0] pushData;
  logic             doPush, doPop;

  assign pushData = strb.pushFromBus ? busData : seqData;
  assign doPush   = strb.push && !strb.flush;
  assign doPop    = strb.pop && !strb.flush;
  assign full     = (level == LVLW'(DEPTH));
  assign empty    = (level == '0);
  assign headData = store[rdPtr];

  function automatic logic [PTRW-1:0] nextPtr(input logic [PTRW-1:0] p);
    return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) store[e] <= '0;
      else if (doPush && wrPtr == PTRW'(e)) store[e] <= pushData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    doPush && !doPop |-> !full);
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    doPop |-> !empty);
  p_level_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVLW'(DEPTH));
endmodule

// File: rtl/flashfifoCtrl.sv
module flashfifoCtrl
  import flashfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DATAW = 8,
  localparam int LVLW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [1:0]       regAddr,
  input  logic [RegW-1:0]  regWdata,
  output logic [RegW-1:0]  regRdata,
  input  logic             seqReadDir,
  input  logic             seqActive,
  input  logic             seqInValid,
  output logic             seqInReady,
  output logic             seqOutValid,
  input  logic             seqOutReady,
  input  logic             seqDone,
  input  logic             seqError,
  output logic             seqAbort,
  output logic             irq,
  input  logic [DATAW-1:0] headData,
  input  logic [LVLW-1:0]  level,
  input  logic             full,
  input  logic             empty,
  output fifoStrobes_t     strb
);
  logic       enBit, abortBit, errFlag, doneFlag;
  logic [4:0] thr, ie;
  logic       gate, ctrlWr, clrWr, dataWr, dataRd;
  logic       busPush, busPop, seqPush, seqPop;
  logic [6:0] lvlX, freeX, thrX;
  logic       thrFlag, busy;
  logic [4:0] flagVec;

  assign ctrlWr = regWrEn && regAddr == AddrCtrl;
  assign clrWr  = regWrEn && regAddr == AddrClear;
  assign dataWr = regWrEn && regAddr == AddrData;
  assign dataRd = regRdEn && regAddr == AddrData;
  assign gate   = enBit && !abortBit;

  assign seqInReady  = gate && seqReadDir && !full;
  assign seqOutValid = gate && !seqReadDir && !empty;
  assign seqAbort    = abortBit;

  assign seqPush = seqInValid && seqInReady;
  assign seqPop  = seqOutValid && seqOutReady;
  assign busPush = dataWr && gate && !seqReadDir && !full;
  assign busPop  = dataRd && gate && seqReadDir && !empty;

  always_comb begin
    strb.push        = busPush || seqPush;
    strb.pushFromBus = !seqReadDir;
    strb.pop         = busPop || seqPop;
    strb.flush       = !gate;
  end

  // control register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enBit    <= 1'b0;
      abortBit <= 1'b0;
      thr      <= '0;
      ie       <= '0;
    end else begin
      if (ctrlWr) begin
        enBit <= regWdata[0];
        thr   <= regWdata[12:8];
        ie    <= regWdata[20:16];
      end
      if (ctrlWr && regWdata[1]) abortBit <= 1'b1;
      else if (abortBit && !seqActive) abortBit <= 1'b0;
    end
  end

  // sticky flags, set wins over clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      errFlag  <= 1'b0;
      doneFlag <= 1'b0;
    end else begin
      if (seqError) errFlag <= 1'b1;
      else if (clrWr && regWdata[0]) errFlag <= 1'b0;
      if (seqDone) doneFlag <= 1'b1;
      else if (clrWr && regWdata[1]) doneFlag <= 1'b0;
    end
  end

  assign lvlX    = 7'(level);
  assign freeX   = 7'(DEPTH) - lvlX;
  assign thrX    = 7'(thr);
  assign thrFlag = seqReadDir ? (lvlX > thrX) : (freeX > thrX);
  assign busy    = seqActive || !empty;
  assign flagVec = {2'b00, thrFlag, doneFlag, errFlag};
  assign irq     = |(flagVec & ie);

  always_comb begin
    regRdata = '0;
    case (regAddr)
      AddrCtrl: begin
        regRdata[0]     = enBit;
        regRdata[1]     = abortBit;
        regRdata[12:8]  = thr;
        regRdata[20:16] = ie;
      end
      AddrStat: begin
        regRdata[4:0]  = flagVec;
        regRdata[5]    = busy;
        regRdata[13:8] = 6'(level);
      end
      AddrData:
        if (gate && seqReadDir && !empty) regRdata[DATAW-1:0] = headData;
      default: regRdata = '0;
    endcase
  end

  p_done_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> doneFlag);
  p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag && !(clrWr && regWdata[1]) |=> doneFlag);
  p_abort_no_err_r7: assert property (@(posedge clk) disable iff (!rstN)
    abortBit && !errFlag && !seqError |=> !errFlag);
  p_abort_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    abortBit && !seqActive && !(ctrlWr && regWdata[1]) |=> !abortBit);
  p_off_no_xfer_r8: assert property (@(posedge clk) disable iff (!rstN)
    !enBit |-> !strb.push && !strb.pop);
endmodule

// File: rtl/flashfifoStatus.sv
module flashfifoStatus
  import flashfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DATAW = 8,
  localparam int LVLW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [1:0]       regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  logic             seqReadDir,
  input  logic             seqActive,
  input  logic             seqInValid,
  input  logic [DATAW-1:0] seqInData,
  output logic             seqInReady,
  output logic             seqOutValid,
  output logic [DATAW-1:0] seqOutData,
  input  logic             seqOutReady,
  input  logic             seqDone,
  input  logic             seqError,
  output logic             seqAbort,
  output logic             irq
);
  fifoStrobes_t     strb;
  logic [DATAW-1:0] headData;
  logic [LVLW-1:0]  level;
  logic             full, empty;

  assign seqOutData = headData;

  flashfifoCtrl #(.DEPTH(DEPTH), .DATAW(DATAW)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .seqReadDir(seqReadDir), .seqActive(seqActive),
    .seqInValid(seqInValid), .seqInReady(seqInReady),
    .seqOutValid(seqOutValid), .seqOutReady(seqOutReady),
    .seqDone(seqDone), .seqError(seqError), .seqAbort(seqAbort),
    .irq(irq), .headData(headData), .level(level), .full(full),
    .empty(empty), .strb(strb)
  );

  flashfifoDatapath #(.DEPTH(DEPTH), .DATAW(DATAW)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busData(regWdata[DATAW-1:0]),
    .seqData(seqInData), .headData(headData), .level(level),
    .full(full), .empty(empty)
  );

  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> empty);
endmodule

// File: tb/flashfifoStatus_tb.sv
module flashfifoStatus_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 0, regRdEn = 0;
  logic [1:0]  regAddr = 0;
  logic [31:0] regWdata = 0;
  logic [31:0] regRdata;
  logic        seqReadDir = 1, seqActive = 0, seqInValid = 0;
  logic [7:0]  seqInData = 0;
  logic        seqInReady, seqOutValid, seqOutReady = 0;
  logic [7:0]  seqOutData;
  logic        seqDone = 0, seqError = 0, seqAbort, irq;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flashfifoStatus #(.DEPTH(DEPTH)) dut_i (.*);

  // {dir(1=read), fill[4:0], thr[4:0], expected flag} -- R4 vectors
  localparam logic [11:0] TV [12] = '{
    {1'b1, 5'd0,  5'd0,  1'b0}, {1'b1, 5'd1,  5'd0,  1'b1},
    {1'b1, 5'd3,  5'd3,  1'b0}, {1'b1, 5'd4,  5'd3,  1'b1},
    {1'b1, 5'd16, 5'd15, 1'b1}, {1'b1, 5'd16, 5'd16, 1'b0},
    {1'b0, 5'd0,  5'd0,  1'b1}, {1'b0, 5'd16, 5'd0,  1'b0},
    {1'b0, 5'd12, 5'd3,  1'b1}, {1'b0, 5'd13, 5'd3,  1'b0},
    {1'b0, 5'd0,  5'd16, 1'b0}, {1'b0, 5'd0,  5'd15, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWdata = d;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1; regAddr = a;
    #1 d = regRdata;
    @(posedge clk);
    @(negedge clk);
    regRdEn = 0;
  endtask

  task automatic seqPush(input logic [7:0] b);
    @(negedge clk);
    seqInValid = 1; seqInData = b;
    @(posedge clk);
    @(negedge clk);
    seqInValid = 0;
  endtask

  task automatic pulse(input bit done, input bit err);
    @(negedge clk);
    seqDone = done; seqError = err;
    @(posedge clk);
    @(negedge clk);
    seqDone = 0; seqError = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;

    // R1 reset state
    regRead(0, r); chk("R1 ctrl", r, 0);
    regRead(1, r); chk("R1 status", r, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R4 threshold table
    for (int i = 0; i < 12; i++) begin
      logic dir; int fill; logic [4:0] th;
      dir = TV[i][11]; fill = int'(TV[i][10:6]); th = TV[i][5:1];
      regWrite(0, 0);
      @(negedge clk) seqReadDir = dir;
      regWrite(0, {19'b0, th, 8'h01});
      for (int k = 0; k < fill; k++) begin
        if (dir) seqPush(8'(k));
        else regWrite(3, k);
      end
      regRead(1, r);
      chk("R4 threshold", {31'b0, r[2]}, {31'b0, TV[i][0]});
      chk("R2 level", {26'b0, r[13:8]}, fill);
    end

    // R2 read order
    regWrite(0, 0);
    @(negedge clk) seqReadDir = 1;
    regWrite(0, 32'h1);
    seqPush(8'hA1); seqPush(8'hB2); seqPush(8'hC3);
    regRead(3, r); chk("R2 byte0", r, 32'hA1);
    regRead(3, r); chk("R2 byte1", r, 32'hB2);
    regRead(3, r); chk("R2 byte2", r, 32'hC3);
    // R9 empty read
    regRead(3, r); chk("R9 empty read", r, 0);
    regRead(1, r); chk("R9 level after empty read", {26'b0, r[13:8]}, 0);

    // R9 full write dropped, R3 order
    regWrite(0, 0);
    @(negedge clk) seqReadDir = 0;
    regWrite(0, 32'h1);
    for (int k = 0; k < DEPTH; k++) regWrite(3, 8'h40 + k);
    regWrite(3, 8'h77);
    regRead(1, r); chk("R9 level full", {26'b0, r[13:8]}, DEPTH);
    @(negedge clk) seqOutReady = 1;
    for (int k = 0; k < DEPTH; k++) begin
      #1;
      chk("R3 out valid", {31'b0, seqOutValid}, 1);
      chk("R3 out data", {24'b0, seqOutData}, 8'h40 + k);
      @(negedge clk);
    end
    #1 chk("R9 dropped byte absent", {31'b0, seqOutValid}, 0);
    seqOutReady = 0;

    // R5 / R6 flags and interrupt
    regWrite(0, 32'h0002_0001);           // enable done interrupt only
    pulse(1, 0);
    regRead(1, r); chk("R5 done set", {31'b0, r[1]}, 1);
    chk("R6 irq on done", {31'b0, irq}, 1);
    regWrite(2, 32'h2);
    regRead(1, r); chk("R5 done cleared", {31'b0, r[1]}, 0);
    chk("R6 irq off", {31'b0, irq}, 0);
    pulse(0, 1);
    chk("R6 error not enabled", {31'b0, irq}, 0);
    regWrite(2, 32'h2);
    regRead(1, r); chk("R5 error kept", {31'b0, r[0]}, 1);
    regWrite(2, 32'h1);
    regRead(1, r); chk("R5 error cleared", {31'b0, r[0]}, 0);
    // set wins against clear in the same cycle
    @(negedge clk);
    regWrEn = 1; regAddr = 2; regWdata = 32'h2; seqDone = 1;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 0; seqDone = 0;
    regRead(1, r); chk("R5 set wins", {31'b0, r[1]}, 1);
    regWrite(2, 32'h3);
    regWrite(0, 32'h0004_0001);           // threshold interrupt, write dir, empty
    chk("R6 irq on threshold", {31'b0, irq}, 1);

    // R10 busy
    regWrite(0, 32'h1);
    @(negedge clk) seqActive = 1;
    regRead(1, r); chk("R10 busy active", {31'b0, r[5]}, 1);
    @(negedge clk) seqActive = 0;
    regWrite(3, 8'h11);
    regRead(1, r); chk("R10 busy nonempty", {31'b0, r[5]}, 1);

    // R7 abort held while sequencer active
    regWrite(3, 8'h22); regWrite(3, 8'h33);
    @(negedge clk) seqActive = 1;
    regWrite(0, 32'h3);
    repeat (2) @(negedge clk);
    regRead(0, r); chk("R7 abort pending", {31'b0, r[1]}, 1);
    chk("R7 seqAbort", {31'b0, seqAbort}, 1);
    regRead(1, r); chk("R7 flushed", {26'b0, r[13:8]}, 0);
    chk("R7 no error", {31'b0, r[0]}, 0);
    @(negedge clk) seqActive = 0;
    @(negedge clk);
    regRead(0, r); chk("R7 abort retired", {31'b0, r[1]}, 0);
    chk("R7 enable kept", {31'b0, r[0]}, 1);

    // R8 disable
    @(negedge clk) seqReadDir = 1;
    seqPush(8'h55);
    regWrite(0, 0);
    regRead(1, r); chk("R8 flushed on disable", {26'b0, r[13:8]}, 0);
    #1 chk("R8 in ready low", {31'b0, seqInReady}, 0);
    seqPush(8'h66);
    regRead(1, r); chk("R8 push ignored", {26'b0, r[13:8]}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule